// File: doc/BRIEF.md
# Camera Frame Capture Ring Recorder

This block takes pixels from an image sensor that presents one byte per pixel-clock rising edge, together with a line-valid strobe (HSYNC) and a frame-start strobe (VSYNC). Two bytes form one 16-bit RGB565 pixel, with the high byte first. Each pixel is stored as one word in an external asynchronous SRAM array built from two 16-bit chips.

The storage is treated as a ring of fixed-size frame slots. Slot `k` begins at linear word address `k * COLS * ROWS`. Bit `CHIP_AW` of the linear address chooses which chip is enabled, and the lower `CHIP_AW` bits drive the shared address bus. The write pointer wraps once the last slot is done, so the array always holds the most recent `SLOTS` frames.

A crash strobe stops recording so that the history leading up to the event is kept. The block then reports which slot holds the oldest retained frame and how many complete frames are valid, for a later dump stage.

The sensor pins are sampled in the system clock domain through two-stage synchronisers. A small word FIFO separates pixel arrival from the multi-cycle SRAM write. The block also drives a divided clock to the sensor.

Top module: `cam_ring_recorder`

## Requirements
- R1: While reset is active and on the first cycle after it, `sram_we_n` is 1, both `sram_ce_n` bits are 1, `sram_oe_n` is 1, `sram_drive` is 0, `frozen` is 0, and both `valid_frames` and `oldest_slot` are 0.
- R2: A pixel word is formed from two bytes taken on pixel-clock rising edges while `cam_hsync` is 1. The first byte becomes bits 15:8 and the second byte becomes bits 7:0. Bytes taken while `cam_hsync` is 0, and all bytes before the first rising edge of `cam_vsync` after reset, produce no SRAM write. Every accepted word is written exactly once and in arrival order.
- R3: Only the first `COLS` pixels of a line and the first `ROWS` lines of a frame are written. Any further pixels or lines are dropped.
- R4: The word for pixel (row `r`, column `c`) of the frame in slot `s` is written at linear address `s*COLS*ROWS + r*COLS + c`. The `sram_addr` port carries the low `CHIP_AW` bits of that address. When bit `CHIP_AW` of the address is 0, only `sram_ce_n[0]` is low; when it is 1, only `sram_ce_n[1]` is low. No chip enable is low outside a write.
- R5: Every write follows the same sequence. One cycle with the address, data and chip enable set up and `sram_we_n` high. Then `sram_we_n` low for `WE_LOW` cycles (at least two) with the address and data stable. Then one cycle with `sram_we_n` high and the address, data and `sram_drive` still held. `sram_oe_n` stays at 1 throughout.
- R6: Slots are filled in the order 0, 1, …, `SLOTS-1` and then 0 again. `valid_frames` counts completed frames up to a maximum of `SLOTS`. `oldest_slot` is 0 until the ring has wrapped once; after that it equals the slot the next frame will be written to.
- R7: If `crash_in` rises after at least one word of a frame has been written, that frame is still written in full. Then `frozen` goes to 1 and stays there until reset, and no further SRAM write takes place.
- R8: If `crash_in` rises while no word of a new frame has been written yet, `frozen` goes to 1 within a few cycles, and nothing of any later frame is written.
- R9: `cam_xclk` toggles once every `XCLK_HALF` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cam_pclk | input | 1 | Sensor pixel clock, sampled |
| cam_hsync | input | 1 | Line-valid strobe from the sensor |
| cam_vsync | input | 1 | Frame-start strobe from the sensor |
| cam_data | input | 8 | Sensor pixel byte |
| cam_xclk | output | 1 | Divided clock driven to the sensor |
| crash_in | input | 1 | Crash strobe, asynchronous |
| sram_addr | output | CHIP_AW | Shared SRAM address bus |
| sram_wdata | output | 16 | SRAM write data |
| sram_drive | output | 1 | Enables the pad drivers of the SRAM data bus |
| sram_ce_n | output | 2 | Active-low chip enables, one per chip |
| sram_we_n | output | 1 | Active-low write strobe |
| sram_oe_n | output | 1 | Active-low output enable, held high |
| frozen | output | 1 | Recording stopped after a crash |
| oldest_slot | output | SLOT_W | Slot holding the oldest valid frame |
| valid_frames | output | SLOT_W | Number of complete frames held |

## Verification
The bench runs the block with a small geometry of 4x2 pixels and three slots, so that the third slot falls entirely in the second chip and every ring event happens within a few frames. It drives the following stimulus:
- Lines sent before the first frame start, which must leave the SRAM untouched.
- Stray bytes while the line strobe is low, which must not shift the byte pairing.
- Over-long lines and extra lines, which must reach the SRAM in clipped form.
- A run of four frames, which exposes the wrap and the change of oldest slot, and separates the not-yet-full state from the full state.

Two crash cases, one between frames and one mid-frame, show whether the block completes only the frame in progress and whether any write slips through after the freeze.

// File: rtl/cam_ring_pkg.sv
// Shared types for the camera ring recorder.
package cam_ring_pkg;

    // Phases of one asynchronous SRAM write
    typedef enum logic [1:0] {
        WS_IDLE,
        WS_SETUP,
        WS_STROBE,
        WS_HOLD
    } wr_state_t;

endpackage

// File: rtl/cam_byte_pair.sv
// Samples the sensor bus in the system clock domain and pairs bytes into
// 16-bit pixels, high byte first, while the line strobe is high.
// Tracks the column and row so that pixels outside COLS x ROWS are dropped.
// Capture is armed by the first frame start after reset.
// Assumes the system clock is at least four times the pixel clock, and that
// the data is stable for two system clocks around each pixel-clock rise.
module cam_byte_pair #(
    parameter int COLS = 320,
    parameter int ROWS = 240,
    localparam int COL_W = $clog2(COLS + 1),
    localparam int ROW_W = $clog2(ROWS + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        pclk,
    input  logic        hsync,
    input  logic        vsync,
    input  logic [7:0]  data,
    output logic        push,
    output logic [15:0] word
);
    logic [10:0]      meta_q, sync_q;
    logic             pclk_d, hs_d, vs_d;
    logic             armed, phase;
    logic [7:0]       hi_q;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row;
    logic             pclk_rise, hs_fall, vs_rise;

    // Edge detection on the synchronised strobes
    always_comb begin
        pclk_rise = sync_q[10] & ~pclk_d;
        hs_fall   = ~sync_q[9] & hs_d;
        vs_rise   = sync_q[8] & ~vs_d;
    end

    // Synchronise the bus, track the position and emit completed pixels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            pclk_d <= 1'b0;
            hs_d   <= 1'b0;
            vs_d   <= 1'b0;
            armed  <= 1'b0;
            phase  <= 1'b0;
            hi_q   <= '0;
            col    <= '0;
            row    <= '0;
            push   <= 1'b0;
            word   <= '0;
        end else begin
            meta_q <= {pclk, hsync, vsync, data};
            sync_q <= meta_q;
            pclk_d <= sync_q[10];
            hs_d   <= sync_q[9];
            vs_d   <= sync_q[8];
            push   <= 1'b0;
            if (vs_rise) begin
                armed <= 1'b1;
                phase <= 1'b0;
                col   <= '0;
                row   <= '0;
            end else if (hs_fall) begin
                phase <= 1'b0;
                col   <= '0;
                if (col != '0 && row != ROW_W'(ROWS)) begin
                    row <= row + 1'b1;
                end
            end else if (pclk_rise && sync_q[9]) begin
                if (!phase) begin
                    hi_q  <= sync_q[7:0];
                    phase <= 1'b1;
                end else begin
                    phase <= 1'b0;
                    if (col != COL_W'(COLS)) begin
                        col <= col + 1'b1;
                    end
                    if (armed && enable && col < COL_W'(COLS) && row < ROW_W'(ROWS)) begin
                        push <= 1'b1;
                        word <= {hi_q, sync_q[7:0]};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ring_word_fifo.sv
// Small first-in first-out store that separates pixel arrival from SRAM
// writes. Assumes the writer drains faster on average than pixels arrive.
module ring_word_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty,
    output logic             full
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [PW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    // Status flags from the occupancy
    always_comb begin
        empty = (cnt == '0);
        full  = (cnt == CW'(DEPTH));
        rdata = mem[rp];
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push && !full) begin
                wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop && !empty) begin
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            cnt <= cnt + CW'(push && !full) - CW'(pop && !empty);
        end
    end

    // Storage write
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[wp] <= wdata;
        end
    end
endmodule

// File: rtl/sram_write_seq.sv
// Runs one asynchronous SRAM write: a setup cycle, WE_LOW strobe cycles and
// one hold cycle. The top bit of the linear address picks the chip.
// Assumes start is only raised while busy is low.
module sram_write_seq
    import cam_ring_pkg::*;
#(
    parameter int LIN_AW = 21,
    parameter int WE_LOW = 2,
    localparam int SW = $clog2(WE_LOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LIN_AW-1:0] addr_in,
    input  logic [15:0]       data_in,
    output logic              busy,
    output logic              done,
    output logic [LIN_AW-2:0] sram_addr,
    output logic [15:0]       sram_wdata,
    output logic              sram_drive,
    output logic [1:0]        sram_ce_n,
    output logic              sram_we_n
);
    wr_state_t         state;
    logic [SW-1:0]     cnt;
    logic [LIN_AW-1:0] addr_q;
    logic [15:0]       data_q;

    // Pin decode from the state register
    always_comb begin
        busy       = (state != WS_IDLE);
        done       = (state == WS_HOLD);
        sram_we_n  = (state != WS_STROBE);
        sram_drive = busy;
        sram_addr  = addr_q[LIN_AW-2:0];
        sram_wdata = data_q;
        sram_ce_n  = 2'b11;
        if (busy) begin
            sram_ce_n[addr_q[LIN_AW-1]] = 1'b0;
        end
    end

    // Sequence through setup, strobe and hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= WS_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    addr_q <= addr_in;
                    data_q <= data_in;
                    state  <= WS_SETUP;
                end
                WS_SETUP: begin
                    cnt   <= '0;
                    state <= WS_STROBE;
                end
                WS_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == SW'(WE_LOW - 1)) begin
                        state <= WS_HOLD;
                    end
                end
                default: state <= WS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame_ring_ctrl.sv
// Keeps the slot pointer, the word offset inside the frame and the full flag,
// and forms the linear write address. A synchronised crash strobe stops
// recording once the frame in progress (if any word of it is written) ends.
module frame_ring_ctrl #(
    parameter int SLOTS       = 27,
    parameter int FRAME_WORDS = 76800,
    parameter int LIN_AW      = 21,
    localparam int SLOT_W = $clog2(SLOTS + 1),
    localparam int OFS_W  = $clog2(FRAME_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              crash,
    input  logic              word_done,
    input  logic              wr_busy,
    output logic [LIN_AW-1:0] wr_addr,
    output logic              hold_off,
    output logic              frozen,
    output logic [SLOT_W-1:0] oldest_slot,
    output logic [SLOT_W-1:0] valid_frames
);
    logic [1:0]        crash_sync;
    logic              pending, full;
    logic [SLOT_W-1:0] slot;
    logic [OFS_W-1:0]  ofs;
    logic [LIN_AW-1:0] base;

    // Address and report outputs
    always_comb begin
        wr_addr      = base + LIN_AW'(ofs);
        hold_off     = frozen | (pending & (ofs == '0));
        oldest_slot  = full ? slot : '0;
        valid_frames = full ? SLOT_W'(SLOTS) : slot;
    end

    // Crash capture and freeze at a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crash_sync <= '0;
            pending    <= 1'b0;
            frozen     <= 1'b0;
        end else begin
            crash_sync <= {crash_sync[0], crash};
            if (crash_sync[1]) begin
                pending <= 1'b1;
            end
            if (pending && ofs == '0 && !wr_busy && !word_done) begin
                frozen <= 1'b1;
            end
        end
    end

    // Advance the offset and the slot ring on each finished word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot <= '0;
            ofs  <= '0;
            base <= '0;
            full <= 1'b0;
        end else if (word_done) begin
            if (ofs == OFS_W'(FRAME_WORDS - 1)) begin
                ofs <= '0;
                if (slot == SLOT_W'(SLOTS - 1)) begin
                    slot <= '0;
                    base <= '0;
                    full <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                    base <= base + LIN_AW'(FRAME_WORDS);
                end
            end else begin
                ofs <= ofs + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cam_ring_recorder.sv
// Top of the camera ring recorder. Pairs sensor bytes into pixels, buffers
// them in a small FIFO and writes them into a two-chip SRAM that is run as a
// ring of frame slots. A crash strobe freezes the ring for a later dump.
// Assumes SLOTS*COLS*ROWS fits in 2^(CHIP_AW+1) words.
module cam_ring_recorder #(
    parameter int COLS       = 320,
    parameter int ROWS       = 240,
    parameter int SLOTS      = 27,
    parameter int CHIP_AW    = 20,
    parameter int FIFO_DEPTH = 4,
    parameter int WE_LOW     = 2,
    parameter int XCLK_HALF  = 2,
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cam_pclk,
    input  logic               cam_hsync,
    input  logic               cam_vsync,
    input  logic [7:0]         cam_data,
    output logic               cam_xclk,
    input  logic               crash_in,
    output logic [CHIP_AW-1:0] sram_addr,
    output logic [15:0]        sram_wdata,
    output logic               sram_drive,
    output logic [1:0]         sram_ce_n,
    output logic               sram_we_n,
    output logic               sram_oe_n,
    output logic               frozen,
    output logic [SLOT_W-1:0]  oldest_slot,
    output logic [SLOT_W-1:0]  valid_frames
);
    localparam int FRAME_WORDS = COLS * ROWS;
    localparam int LIN_AW      = CHIP_AW + 1;
    localparam int XW          = $clog2(XCLK_HALF) + 1;

    logic              fifo_push, fifo_full, fifo_empty, wr_start;
    logic [15:0]       pix_word, fifo_word;
    logic              wr_busy, wr_done, hold_off;
    logic [LIN_AW-1:0] wr_addr;
    logic [XW-1:0]     xcnt;

    assign sram_oe_n = 1'b1;
    assign wr_start  = !fifo_empty && !wr_busy && !hold_off;

    // Sensor clock divider
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xcnt     <= '0;
            cam_xclk <= 1'b0;
        end else if (xcnt == XW'(XCLK_HALF - 1)) begin
            xcnt     <= '0;
            cam_xclk <= ~cam_xclk;
        end else begin
            xcnt <= xcnt + 1'b1;
        end
    end

    cam_byte_pair #(.COLS(COLS), .ROWS(ROWS)) u_pair (
        .clk(clk), .rst_n(rst_n), .enable(!frozen),
        .pclk(cam_pclk), .hsync(cam_hsync), .vsync(cam_vsync), .data(cam_data),
        .push(fifo_push), .word(pix_word)
    );

    ring_word_fifo #(.WIDTH(16), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(pix_word),
        .pop(wr_start), .rdata(fifo_word), .empty(fifo_empty), .full(fifo_full)
    );

    sram_write_seq #(.LIN_AW(LIN_AW), .WE_LOW(WE_LOW)) u_wr (
        .clk(clk), .rst_n(rst_n), .start(wr_start), .addr_in(wr_addr),
        .data_in(fifo_word), .busy(wr_busy), .done(wr_done),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_drive(sram_drive),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n)
    );

    frame_ring_ctrl #(.SLOTS(SLOTS), .FRAME_WORDS(FRAME_WORDS), .LIN_AW(LIN_AW)) u_ring (
        .clk(clk), .rst_n(rst_n), .crash(crash_in), .word_done(wr_done),
        .wr_busy(wr_busy), .wr_addr(wr_addr), .hold_off(hold_off),
        .frozen(frozen), .oldest_slot(oldest_slot), .valid_frames(valid_frames)
    );
endmodule

// File: rtl/cam_ring_recorder_chk.sv
// Property checker for the camera ring recorder, bound to the top module.
module cam_ring_recorder_chk #(
    parameter int SLOTS   = 27,
    parameter int CHIP_AW = 20,
    parameter int WE_LOW  = 2,
    parameter int SLOT_W  = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sram_we_n,
    input logic               sram_oe_n,
    input logic               sram_drive,
    input logic [1:0]         sram_ce_n,
    input logic [CHIP_AW-1:0] sram_addr,
    input logic [15:0]        sram_wdata,
    input logic               frozen,
    input logic [SLOT_W-1:0]  oldest_slot,
    input logic [SLOT_W-1:0]  valid_frames,
    input logic               fifo_push,
    input logic               fifo_full
);
    logic [7:0] low_cnt;

    // Length of the current write strobe
    always_ff @(posedge clk) begin
        if (!rst_n || sram_we_n) low_cnt <= '0;
        else if (low_cnt != 8'hFF) low_cnt <= low_cnt + 1'b1;
    end

    AST_WE_LOW_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> low_cnt >= 8'(WE_LOW)); // R5
    AST_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_we_n && $past(!sram_we_n)) |-> ($stable(sram_addr) && $stable(sram_wdata))); // R5
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_drive && $stable(sram_addr) && $stable(sram_wdata))); // R5
    AST_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sram_oe_n); // R5
    AST_ONE_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> $countones(~sram_ce_n) == 1); // R4
    AST_CE_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sram_ce_n) <= 1); // R4
    AST_RING_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (oldest_slot < SLOT_W'(SLOTS)) && (valid_frames <= SLOT_W'(SLOTS))); // R6
    AST_OLDEST_BEFORE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_frames < SLOT_W'(SLOTS)) |-> (oldest_slot == '0)); // R6
    AST_FROZEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> frozen); // R7
    AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> (sram_we_n && !sram_drive)); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_full)); // R2
endmodule

bind cam_ring_recorder cam_ring_recorder_chk #(
    .SLOTS(SLOTS), .CHIP_AW(CHIP_AW), .WE_LOW(WE_LOW), .SLOT_W(SLOT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_drive(sram_drive), .sram_ce_n(sram_ce_n), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .frozen(frozen), .oldest_slot(oldest_slot),
    .valid_frames(valid_frames), .fifo_push(fifo_push), .fifo_full(fifo_full)
);

// File: tb/cam_ring_recorder_tb_top.sv
// Scoreboard bench: the driver queues every word it expects written, and the
// monitor pops and compares each SRAM write as it completes.
module cam_ring_recorder_tb_top;
    localparam int COLS = 4, ROWS = 2, SLOTS = 3, CHIP_AW = 4;
    localparam int WE_LOW = 2, XCLK_HALF = 2, FW = COLS * ROWS;
    localparam int LIN = CHIP_AW + 1, SLOT_W = $clog2(SLOTS + 1);

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n = 1'b0, pclk = 1'b0, hsync = 1'b0, vsync = 1'b0, crash = 1'b0;
    logic [7:0] data = '0;
    logic cam_xclk, sram_drive, sram_we_n, sram_oe_n, frozen;
    logic [CHIP_AW-1:0] sram_addr;
    logic [15:0] sram_wdata;
    logic [1:0] sram_ce_n;
    logic [SLOT_W-1:0] oldest_slot, valid_frames;

    cam_ring_recorder #(.COLS(COLS), .ROWS(ROWS), .SLOTS(SLOTS), .CHIP_AW(CHIP_AW),
        .FIFO_DEPTH(4), .WE_LOW(WE_LOW), .XCLK_HALF(XCLK_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .cam_pclk(pclk), .cam_hsync(hsync),
        .cam_vsync(vsync), .cam_data(data), .cam_xclk(cam_xclk), .crash_in(crash),
        .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_drive(sram_drive),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .frozen(frozen), .oldest_slot(oldest_slot), .valid_frames(valid_frames));

    int checks = 0, errors = 0, exp_slot = 0, cycles = 0;
    logic [LIN+15:0] exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] pix(input int f, input int r, input int c);
        return {4'(f), 4'(r), 8'(c * 16 + 5)};
    endfunction

    // Monitor: checks each write's strobe timing and compares it to the queue
    logic we_prev = 1'b1, stable_ok = 1'b1;
    logic [LIN-1:0] w_addr;
    logic [15:0] w_data;
    int low_cnt = 0;
    always @(negedge clk) begin
        logic [LIN-1:0] cur;
        logic [LIN+15:0] e;
        cur = {~sram_ce_n[1], sram_addr};
        if (we_prev && !sram_we_n) begin
            low_cnt = 1; w_addr = cur; w_data = sram_wdata; stable_ok = 1'b1;
            chk(sram_ce_n == 2'b10 || sram_ce_n == 2'b01, "R4", "one chip enabled",
                int'(sram_ce_n), 1);
        end else if (!sram_we_n) begin
            low_cnt++;
            if (cur != w_addr || sram_wdata != w_data) stable_ok = 1'b0;
        end else if (!we_prev && rst_n) begin
            chk(low_cnt >= WE_LOW, "R5", "WE low cycles", low_cnt, WE_LOW);
            chk(stable_ok && sram_drive && cur == w_addr && sram_wdata == w_data,
                "R5", "hold after WE", int'(stable_ok), 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2", "unexpected write at address", int'(w_addr), -1);
            end else begin
                e = exp_q.pop_front();
                chk(w_addr == e[LIN+15:16], "R4", "write address", int'(w_addr),
                    int'(e[LIN+15:16]));
                chk(w_data == e[15:0], "R2", "write data", int'(w_data), int'(e[15:0]));
            end
        end
        we_prev = sram_we_n;
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        data = b; pclk = 1'b0; ticks(4);
        pclk = 1'b1; ticks(4);
        pclk = 1'b0;
    endtask

    // Driver: one line; queues the words the block must write
    task automatic send_line(input int f, input int r, input int npix, input bit expect_w);
        logic [15:0] p;
        hsync = 1'b1; ticks(2);
        for (int c = 0; c < npix; c++) begin
            p = pix(f, r, c);
            if (expect_w && c < COLS && r < ROWS)
                exp_q.push_back({LIN'(exp_slot * FW + r * COLS + c), p});
            send_byte(p[15:8]);
            send_byte(p[7:0]);
        end
        hsync = 1'b0; ticks(6);
        send_byte(8'hEE);  // stray byte with the line strobe low (R2)
        ticks(4);
    endtask

    task automatic frame_start();
        vsync = 1'b1; ticks(8);
        vsync = 1'b0; ticks(8);
    endtask

    task automatic send_frame(input int f, input bit expect_w);
        frame_start();
        for (int r = 0; r < ROWS; r++) send_line(f, r, COLS, expect_w);
        if (expect_w) exp_slot = (exp_slot + 1) % SLOTS;
        ticks(60);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; crash = 1'b0; ticks(5);
        rst_n = 1'b1; exp_slot = 0;
    endtask

    task automatic drained(input string req);
        chk(exp_q.size() == 0, req, "words still expected", exp_q.size(), 0);
    endtask

    initial begin
        int toggles;
        logic last_x;
        ticks(3);
        chk(sram_we_n && sram_ce_n == 2'b11 && sram_oe_n && !sram_drive,
            "R1", "SRAM pins in reset", int'(sram_ce_n), 3);
        do_reset();
        ticks(1);
        chk(!frozen && valid_frames == 0 && oldest_slot == 0, "R1", "status after reset",
            int'(valid_frames), 0);
        // R9: divided sensor clock
        toggles = 0; last_x = cam_xclk;
        for (int i = 0; i < 40; i++) begin
            ticks(1);
            if (cam_xclk != last_x) toggles++;
            last_x = cam_xclk;
        end
        chk(toggles == 40 / XCLK_HALF, "R9", "xclk toggles in 40 cycles", toggles, 40 / XCLK_HALF);
        // R2: lines before the first frame start are not written
        send_line(9, 0, COLS, 1'b0);
        ticks(40);
        drained("R2");
        // R3: over-long first line and an extra line are clipped
        frame_start();
        send_line(0, 0, COLS + 1, 1'b1);
        send_line(0, 1, COLS, 1'b1);
        send_line(0, 2, COLS, 1'b1);
        exp_slot = 1;
        ticks(60);
        drained("R3");
        chk(valid_frames == 1 && oldest_slot == 0, "R6", "after one frame",
            int'(valid_frames), 1);
        // R8: crash between frames freezes at once
        crash = 1'b1; ticks(10);
        chk(frozen, "R8", "frozen after idle crash", int'(frozen), 1);
        chk(valid_frames == 1 && oldest_slot == 0, "R8", "report after idle crash",
            int'(valid_frames), 1);
        send_frame(5, 1'b0);
        drained("R8");
        chk(frozen, "R8", "still frozen", int'(frozen), 1);

        // R6: fill and wrap the ring
        do_reset();
        ticks(2);
        for (int f = 0; f < 4; f++) begin
            send_frame(f, 1'b1);
            drained("R6");
            chk(valid_frames == ((f + 1 < SLOTS) ? f + 1 : SLOTS), "R6", "valid frames",
                int'(valid_frames), (f + 1 < SLOTS) ? f + 1 : SLOTS);
            chk(oldest_slot == ((f + 1 < SLOTS) ? 0 : (f + 1) % SLOTS), "R6", "oldest slot",
                int'(oldest_slot), (f + 1 < SLOTS) ? 0 : (f + 1) % SLOTS);
        end
        // R7: crash mid-frame completes the frame, then freezes
        frame_start();
        send_line(4, 0, COLS, 1'b1);
        ticks(10);
        crash = 1'b1; ticks(10);
        chk(!frozen, "R7", "not frozen mid-frame", int'(frozen), 0);
        send_line(4, 1, COLS, 1'b1);
        ticks(60);
        drained("R7");
        chk(frozen, "R7", "frozen after frame end", int'(frozen), 1);
        chk(valid_frames == SLOTS && oldest_slot == 2, "R7", "oldest after crash",
            int'(oldest_slot), 2);
        send_frame(6, 1'b0);
        drained("R7");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule